// File: doc/BRIEF.md
# Compare Match Flag Unit

This block watches a running counter value and compares it against a compare register that the CPU loads and reads back. Whenever the two are equal it drives a match signal straight to the downstream waveform logic. The equality is also turned into a sticky compare flag, which can raise an interrupt request.

Capture of the flag runs on the timer clock enable. An equality present at one timer tick is recorded at that tick, and the flag is set at the following tick, one timer clock later. The interrupt-enable input passes the flag on as a request. The flag is cleared either by the interrupt acknowledge strobe or by software writing a one to the flag's bit. If a set and a clear land in the same cycle, the set is kept, so a match is never lost.

Top module: `cmp_match_flag`

## Requirements
- R1: After reset the compare register reads 0x00, the flag is 0 and the interrupt request is 0.
- R2: A cycle with `cmpWrEn` high loads `wrData` into the compare register, and `cmpRdData` shows the new value after that clock edge.
- R3: `matchHit` is high in every cycle where `cntVal` equals the compare register, whether or not `timerTick` is high, and low otherwise.
- R4: An equality sampled at a clock edge with `timerTick` high sets the flag at the next edge with `timerTick` high, and not at the sampling edge itself.
- R5: In cycles with `timerTick` low the flag is never set. A captured equality stays pending until the next tick.
- R6: `intReq` is high exactly when the flag is 1 and `intEnable` is 1.
- R7: `intAck` high clears the flag at that clock edge.
- R8: A cycle with `flagWrEn` high and `wrData` bit 0 equal to 1 clears the flag. With bit 0 equal to 0 the flag keeps its value.
- R9: When a set and a clear (acknowledge or write-one) occur at the same edge, the flag ends up 1.
- R10: An equality that is present only in cycles without `timerTick` and is gone by the next tick does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timerTick | input | 1 | Timer clock enable, one cycle per timer count |
| cntVal | input | 8 | Current counter value |
| cmpWrEn | input | 1 | Load strobe for the compare register |
| flagWrEn | input | 1 | Write strobe for the flag clear bit |
| wrData | input | 8 | CPU write data |
| intEnable | input | 1 | Compare interrupt enable |
| intAck | input | 1 | Interrupt serviced strobe |
| matchHit | output | 1 | Counter equals compare register |
| cmpRdData | output | 8 | Compare register read-back |
| cmpFlag | output | 1 | Sticky compare flag |
| intReq | output | 1 | Compare interrupt request |

## Verification
A stale or wrongly reloaded compare register shows on `cmpRdData` one cycle after the write, and on `matchHit` in the same cycle. A lost or spurious pending equality shows up as `cmpFlag` rising one tick late, one tick early, or not at all. That is visible right after the second tick, so the checks look on both sides of each tick. A wrong clear priority leaves the flag at 0 on the edge where a set and a clear coincide, and `intReq` then falls in the same cycle.

// File: rtl/cmp_flag_pkg.sv
package cmp_flag_pkg;
  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic loadCmp;    // load compare register from write data
    logic sampleEq;   // capture comparator result (timer tick)
  } cmpStrobe_t;
endpackage

// File: rtl/cmp_flag_dp.sv
module cmp_flag_dp
  import cmp_flag_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmpStrobe_t       strobe,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] cntVal,
  output logic [WIDTH-1:0] cmpReg,
  output logic             eqNow,
  output logic             eqPending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cmpReg <= '0;
    else if (strobe.loadCmp) cmpReg <= wrData;
  end

  assign eqNow = (cntVal == cmpReg);

  // Equality seen at a tick, consumed at the next tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               eqPending <= 1'b0;
    else if (strobe.sampleEq) eqPending <= eqNow;
  end
endmodule

// File: rtl/cmp_flag_ctl.sv
module cmp_flag_ctl
  import cmp_flag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       timerTick,
  input  logic       cmpWrEn,
  input  logic       flagWrEn,
  input  logic       clrBit,
  input  logic       intAck,
  input  logic       eqPending,
  output cmpStrobe_t strobe,
  output logic       flag
);
  logic setEvt;
  logic clrEvt;

  always_comb begin
    strobe.loadCmp  = cmpWrEn;
    strobe.sampleEq = timerTick;
  end

  assign setEvt = timerTick & eqPending;
  assign clrEvt = intAck | (flagWrEn & clrBit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (setEvt) flag <= 1'b1;  // set has priority
    else if (clrEvt) flag <= 1'b0;
  end
endmodule

// File: rtl/cmp_match_flag.sv
module cmp_match_flag
  import cmp_flag_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int FLAG_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             timerTick,
  input  logic [WIDTH-1:0] cntVal,
  input  logic             cmpWrEn,
  input  logic             flagWrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             intEnable,
  input  logic             intAck,
  output logic             matchHit,
  output logic [WIDTH-1:0] cmpRdData,
  output logic             cmpFlag,
  output logic             intReq
);
  cmpStrobe_t strobe;
  logic       eqPending;

  cmp_flag_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .timerTick (timerTick),
    .cmpWrEn   (cmpWrEn),
    .flagWrEn  (flagWrEn),
    .clrBit    (wrData[FLAG_BIT]),
    .intAck    (intAck),
    .eqPending (eqPending),
    .strobe    (strobe),
    .flag      (cmpFlag)
  );

  cmp_flag_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .wrData    (wrData),
    .cntVal    (cntVal),
    .cmpReg    (cmpRdData),
    .eqNow     (matchHit),
    .eqPending (eqPending)
  );

  assign intReq = cmpFlag & intEnable;
endmodule

// File: rtl/cmp_match_flag_chk.sv
module cmp_match_flag_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             timerTick,
  input logic             cmpWrEn,
  input logic             flagWrEn,
  input logic [WIDTH-1:0] wrData,
  input logic             intEnable,
  input logic             intAck,
  input logic [WIDTH-1:0] cmpRdData,
  input logic             cmpFlag,
  input logic             intReq
);
  // R2
  cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpWrEn |=> cmpRdData == $past(wrData));

  // R6
  int_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intReq == (cmpFlag && intEnable));

  // R5
  set_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !timerTick |=> !$rose(cmpFlag));

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intAck && !timerTick) |=> !cmpFlag);

  // R8
  zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flagWrEn && !wrData[0] && !intAck && cmpFlag) |=> cmpFlag);
endmodule

bind cmp_match_flag cmp_match_flag_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .timerTick (timerTick),
  .cmpWrEn   (cmpWrEn),
  .flagWrEn  (flagWrEn),
  .wrData    (wrData),
  .intEnable (intEnable),
  .intAck    (intAck),
  .cmpRdData (cmpRdData),
  .cmpFlag   (cmpFlag),
  .intReq    (intReq)
);

// File: tb/sim_cmp_match_flag.sv
module sim_cmp_match_flag;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       timerTick = 1'b0;
  logic [7:0] cntVal = 8'd5;
  logic       cmpWrEn = 1'b0;
  logic       flagWrEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic       intEnable = 1'b0;
  logic       intAck = 1'b0;
  logic       matchHit;
  logic [7:0] cmpRdData;
  logic       cmpFlag;
  logic       intReq;

  always #10 clk = ~clk;  // 50 MHz

  cmp_match_flag u0 (
    .clk(clk), .rst_n(rst_n), .timerTick(timerTick), .cntVal(cntVal),
    .cmpWrEn(cmpWrEn), .flagWrEn(flagWrEn), .wrData(wrData),
    .intEnable(intEnable), .intAck(intAck), .matchHit(matchHit),
    .cmpRdData(cmpRdData), .cmpFlag(cmpFlag), .intReq(intReq)
  );

  typedef struct {
    logic       match;
    logic [7:0] rd;
    logic       flag;
    logic       req;
    string      tag;
  } expItem_t;

  expItem_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state built from the requirements
  logic [7:0] mCmp = 8'd0;
  logic       mPend = 1'b0;
  logic       mFlag = 1'b0;

  task automatic cyc(input logic tk, input logic [7:0] cnt, input logic cw,
                     input logic fw, input logic [7:0] d, input logic ie,
                     input logic ack, input string tag);
    expItem_t e;
    logic setE, clrE;
    @(negedge clk);
    timerTick = tk; cntVal = cnt; cmpWrEn = cw; flagWrEn = fw;
    wrData = d; intEnable = ie; intAck = ack;
    setE = tk && mPend;
    clrE = ack || (fw && d[0]);
    if (tk) mPend = (cnt == mCmp);
    if (cw) mCmp = d;
    if (setE) mFlag = 1'b1;
    else if (clrE) mFlag = 1'b0;
    e.match = (cnt == mCmp);
    e.rd = mCmp;
    e.flag = mFlag;
    e.req = mFlag && ie;
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares after each edge, away from it
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        expItem_t e;
        e = q.pop_front();
        checks++;
        if (matchHit !== e.match || cmpRdData !== e.rd ||
            cmpFlag !== e.flag || intReq !== e.req) begin
          errors++;
          $display("FAIL %s: got match=%b rd=%h flag=%b req=%b, expected match=%b rd=%h flag=%b req=%b",
                   e.tag, matchHit, cmpRdData, cmpFlag, intReq,
                   e.match, e.rd, e.flag, e.req);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state (intEnable high so a stray flag would show)
    cyc(0, 8'd5, 0, 0, 8'h00, 1, 0, "R1");
    // R2 load compare register and read back
    cyc(0, 8'd5, 1, 0, 8'h40, 0, 0, "R2");
    cyc(0, 8'd5, 1, 0, 8'hA7, 0, 0, "R2");
    cyc(0, 8'd5, 1, 0, 8'h40, 0, 0, "R2");
    // R3 match without tick, then mismatch
    cyc(0, 8'h40, 0, 0, 8'h00, 0, 0, "R3");
    cyc(0, 8'h41, 0, 0, 8'h00, 0, 0, "R3");
    cyc(1, 8'h40, 0, 0, 8'h00, 0, 0, "R3");
    cyc(1, 8'h41, 0, 0, 8'h00, 0, 0, "R4");  // pending from previous tick sets flag
    cyc(0, 8'h41, 0, 1, 8'h01, 0, 0, "R8");
    cyc(1, 8'h42, 0, 0, 8'h00, 0, 0, "R10");
    // R10 equality only between ticks
    cyc(0, 8'h40, 0, 0, 8'h00, 0, 0, "R10");
    cyc(1, 8'h41, 0, 0, 8'h00, 0, 0, "R10");
    cyc(1, 8'h42, 0, 0, 8'h00, 0, 0, "R10");
    // R4 sampled at tick, flag only at next tick
    cyc(1, 8'h40, 0, 0, 8'h00, 0, 0, "R4");
    cyc(0, 8'h40, 0, 0, 8'h00, 0, 0, "R4");
    cyc(1, 8'h41, 0, 0, 8'h00, 0, 0, "R4");
    // R6 request follows enable
    cyc(0, 8'h41, 0, 0, 8'h00, 1, 0, "R6");
    cyc(0, 8'h41, 0, 0, 8'h00, 0, 0, "R6");
    cyc(0, 8'h41, 0, 0, 8'h00, 1, 0, "R6");
    // R8 write zero keeps flag, write one clears
    cyc(0, 8'h41, 0, 1, 8'hFE, 1, 0, "R8");
    cyc(0, 8'h41, 0, 1, 8'h01, 1, 0, "R8");
    // R5 pending held over cycles without tick
    cyc(1, 8'h40, 0, 0, 8'h00, 1, 0, "R5");
    for (int i = 0; i < 4; i++) cyc(0, 8'h41, 0, 0, 8'h00, 1, 0, "R5");
    cyc(1, 8'h41, 0, 0, 8'h00, 1, 0, "R5");
    // R7 acknowledge clears
    cyc(0, 8'h41, 0, 0, 8'h00, 1, 1, "R7");
    // R9 set beats acknowledge
    cyc(1, 8'h40, 0, 0, 8'h00, 1, 0, "R9");
    cyc(1, 8'h41, 0, 0, 8'h00, 1, 1, "R9");
    cyc(0, 8'h41, 0, 0, 8'h00, 1, 1, "R7");
    // R9 set beats write-one
    cyc(1, 8'h40, 0, 0, 8'h00, 1, 0, "R9");
    cyc(1, 8'h41, 0, 1, 8'h01, 1, 0, "R9");
    // R3 match against newly loaded value while flag held
    cyc(0, 8'h41, 1, 0, 8'h41, 1, 0, "R3");
    cyc(0, 8'h41, 0, 0, 8'h00, 1, 0, "R3");
    @(negedge clk);
    timerTick = 0; cmpWrEn = 0; flagWrEn = 0; intAck = 0;
    @(posedge clk); #8;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule